// File: doc/BRIEF.md
# Battery/Field Supply Switch Controller

This controller picks the supply source for a contactless node. The node can run from a battery or from energy that a coil draws from a magnetic field. Two digitised comparator levels feed it. One says the rectified coil level is above the field-on threshold. The other says it is below the field-off threshold. Both are resynchronised into the system clock domain. Each one must then hold without a break for its own qualification window before the source changes. The window for going onto field supply is short, in the hundreds of microseconds. The window for going back to battery is long, in the tens of milliseconds. As a result, short bursts of noise on the coil never move the supply.

Entering field supply raises a one-cycle wake pulse for the host. Losing the field returns the node to battery and asserts a reset request toward the host for a fixed number of cycles. A command byte from the serial slave can turn automatic switching off. The node then stays on battery until a power-on reset or until an enable command arrives. No battery-presence input gates the move to field supply, so the move works with no battery at all.

Top module: `supply_switch_ctrl`

## Requirements
- R1: After the synchronous power-on reset `rst`, `field_sel` is 0 (battery), `wake_pulse` and `host_reset_req` are 0, and automatic switching is enabled.
- R2: While on battery with switching enabled, `field_sel` becomes 1 once the synchronised `coil_above_on` level has been high for ON_DELAY consecutive clock cycles.
- R3: A high run on `coil_above_on` shorter than ON_DELAY synchronised cycles causes neither a switch nor a wake pulse. Any drop restarts the count from zero.
- R4: `wake_pulse` is high for exactly one cycle, in the first cycle that `field_sel` reads 1 after being 0, and at no other time.
- R5: While on field supply, `field_sel` returns to 0 once the synchronised `coil_below_off` level has been high for OFF_DELAY consecutive cycles. A shorter run has no effect, and any drop restarts the count.
- R6: A return to battery caused by field loss drives `host_reset_req` high for exactly RST_LEN cycles, starting in the cycle that `field_sel` first reads 0.
- R7: A valid command byte with bits [7:6]=11, bits [2:0]=111 and bit 3 = 0 disables automatic switching. If the controller is on field supply, it returns to battery one cycle after the command takes effect, with no wake pulse and no reset request.
- R8: A valid command byte with bits [7:6]=11, bits [2:0]=111 and bit 3 = 1 re-enables automatic switching. Qualification then starts from a zero count.
- R9: Command bytes that do not match both the bits [7:6]=11 and bits [2:0]=111 pattern leave the enable state unchanged.
- R10: While disabled, `field_sel` stays 0 regardless of the comparator inputs, until `rst` or an enable command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| coil_above_on | input | 1 | Comparator: coil level above field-on threshold (asynchronous) |
| coil_below_off | input | 1 | Comparator: coil level below field-off threshold (asynchronous) |
| cmd_valid | input | 1 | One-cycle strobe: `cmd_byte` holds a received mode byte |
| cmd_byte | input | 8 | Mode byte delivered by the serial slave |
| field_sel | output | 1 | Selected source: 1 field supply, 0 battery |
| wake_pulse | output | 1 | One-cycle pulse on entry to field supply |
| host_reset_req | output | 1 | Reset request toward the host after field loss |

## Verification
A qualification counter stuck or cleared at the wrong time would show up at `field_sel`. The switch would come one or more cycles early or late, or a glitch would be let through. The per-cycle comparison would catch it at the first switching edge. A wrong enable flag would show as a move to field supply while disabled, or a missing one after re-enable. That shows within one qualification window of the command. A wrong reset-pulse counter would show as a wrong `host_reset_req` width within RST_LEN cycles of the battery fallback.

// File: rtl/supply_switch_pkg.sv
package supply_switch_pkg;

  typedef enum logic {
    SRC_BATT  = 1'b0,
    SRC_FIELD = 1'b1
  } src_e;

  // mode byte: [7:6] = 11, [2:0] = 111, [3] = enable value
  function automatic logic is_mode_cmd(input logic [7:0] b);
    return (b[7:6] == 2'b11) && (b[2:0] == 3'b111);
  endfunction

endpackage

// File: rtl/level_sync.sv
module level_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) pipe_q <= '0;
        else     pipe_q <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) pipe_q <= '0;
        else     pipe_q <= {pipe_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/qual_counter.sv
module qual_counter #(
  parameter int DELAY = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic cond_i,
  output logic met_o
);
  localparam int CW = $clog2(DELAY + 1);
  localparam logic [CW-1:0] LIMIT = CW'(DELAY);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                  cnt_q <= '0;
    else if (!cond_i)         cnt_q <= '0;
    else if (cnt_q != LIMIT)  cnt_q <= cnt_q + 1'b1;
  end

  assign met_o = (cnt_q == LIMIT);

  // R3
  restart_chk: assert property (@(posedge clk) disable iff (rst)
    !cond_i |=> cnt_q == '0);

  // R2
  met_needs_cond_chk: assert property (@(posedge clk) disable iff (rst)
    met_o |-> $past(cond_i));
endmodule

// File: rtl/mode_cmd_decoder.sv
module mode_cmd_decoder
  import supply_switch_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cmd_valid,
  input  logic [7:0] cmd_byte,
  output logic       auto_en_o
);
  logic auto_en_q;

  always_ff @(posedge clk) begin
    if (rst)                                    auto_en_q <= 1'b1;
    else if (cmd_valid && is_mode_cmd(cmd_byte)) auto_en_q <= cmd_byte[3];
  end

  assign auto_en_o = auto_en_q;

  // R9
  ignore_chk: assert property (@(posedge clk) disable iff (rst)
    !(cmd_valid && is_mode_cmd(cmd_byte)) |=> $stable(auto_en_q));
endmodule

// File: rtl/supply_switch_ctrl.sv
module supply_switch_ctrl
  import supply_switch_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int ON_DELAY    = 80000,
  parameter int OFF_DELAY   = 6000000,
  parameter int RST_LEN     = 64
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       coil_above_on,
  input  logic       coil_below_off,
  input  logic       cmd_valid,
  input  logic [7:0] cmd_byte,
  output logic       field_sel,
  output logic       wake_pulse,
  output logic       host_reset_req
);
  localparam int RW = $clog2(RST_LEN + 1);
  localparam logic [RW-1:0] RLOAD = RW'(RST_LEN);

  logic above_s, below_s, auto_en, on_met, off_met;
  src_e src_q;
  logic wake_q;
  logic [RW-1:0] rcnt_q;

  level_sync #(.STAGES(SYNC_STAGES)) u_sync_on (
    .clk(clk), .rst(rst), .d_i(coil_above_on), .q_o(above_s));
  level_sync #(.STAGES(SYNC_STAGES)) u_sync_off (
    .clk(clk), .rst(rst), .d_i(coil_below_off), .q_o(below_s));

  mode_cmd_decoder u_cmd (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
    .auto_en_o(auto_en));

  qual_counter #(.DELAY(ON_DELAY)) u_qual_on (
    .clk(clk), .rst(rst),
    .cond_i(above_s && auto_en && (src_q == SRC_BATT)), .met_o(on_met));
  qual_counter #(.DELAY(OFF_DELAY)) u_qual_off (
    .clk(clk), .rst(rst),
    .cond_i(below_s && auto_en && (src_q == SRC_FIELD)), .met_o(off_met));

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q  <= SRC_BATT;
      wake_q <= 1'b0;
      rcnt_q <= '0;
    end else begin
      wake_q <= 1'b0;
      if (rcnt_q != '0) rcnt_q <= rcnt_q - 1'b1;
      unique case (src_q)
        SRC_BATT: begin
          if (auto_en && on_met) begin
            src_q  <= SRC_FIELD;
            wake_q <= 1'b1;
          end
        end
        SRC_FIELD: begin
          if (!auto_en) begin
            src_q <= SRC_BATT;
          end else if (off_met) begin
            src_q  <= SRC_BATT;
            rcnt_q <= RLOAD;
          end
        end
        default: src_q <= SRC_BATT;
      endcase
    end
  end

  assign field_sel      = (src_q == SRC_FIELD);
  assign wake_pulse     = wake_q;
  assign host_reset_req = (rcnt_q != '0);

  // R4
  wake_entry_chk: assert property (@(posedge clk) disable iff (rst)
    wake_pulse |-> field_sel && !$past(field_sel));
  // R4
  entry_wake_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(field_sel) |-> wake_pulse);
  // R7
  disabled_batt_chk: assert property (@(posedge clk) disable iff (rst)
    !auto_en |=> !field_sel);
  // R6
  req_on_loss_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(host_reset_req) |-> $fell(field_sel));
endmodule

// File: tb/test_supply_switch_ctrl.sv
module test_supply_switch_ctrl;
  localparam int SYNC = 2;
  localparam int ON   = 10;
  localparam int OFF  = 30;
  localparam int RLEN = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic above = 1'b0, below = 1'b0, cv = 1'b0;
  logic [7:0] cb = 8'h00;
  logic field_sel, wake_pulse, host_reset_req;

  int checks = 0, errors = 0, cycles = 0;
  int wake_cnt = 0, req_cycles = 0;

  always #2.5 clk = ~clk;

  supply_switch_ctrl #(.SYNC_STAGES(SYNC), .ON_DELAY(ON), .OFF_DELAY(OFF),
    .RST_LEN(RLEN)) i_supply_switch_ctrl (
    .clk(clk), .rst(rst), .coil_above_on(above), .coil_below_off(below),
    .cmd_valid(cv), .cmd_byte(cb), .field_sel(field_sel),
    .wake_pulse(wake_pulse), .host_reset_req(host_reset_req));

  // reference model state
  logic [SYNC-1:0] m_sa, m_sb;
  int m_on, m_off, m_rc;
  logic m_field, m_wake, m_auto;

  function automatic int sat_step(input logic c, input int v, input int lim);
    if (!c) return 0;
    return (v == lim) ? v : v + 1;
  endfunction

  function automatic logic cmd_hit(input logic v, input logic [7:0] b);
    return v && b[7:6] == 2'b11 && b[2:0] == 3'b111;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_sa = '0; m_sb = '0; m_on = 0; m_off = 0; m_rc = 0;
      m_field = 0; m_wake = 0; m_auto = 1;
    end else begin
      logic onm, offm, nf, nw; int nrc;
      onm = (m_on == ON); offm = (m_off == OFF);
      nf = m_field; nw = 0; nrc = (m_rc != 0) ? m_rc - 1 : 0;
      if (!m_field && m_auto && onm) begin nf = 1; nw = 1; end
      else if (m_field && !m_auto) nf = 0;
      else if (m_field && offm) begin nf = 0; nrc = RLEN; end
      m_on  = sat_step(m_sa[SYNC-1] && m_auto && !m_field, m_on, ON);
      m_off = sat_step(m_sb[SYNC-1] && m_auto && m_field, m_off, OFF);
      m_field = nf; m_wake = nw; m_rc = nrc;
      if (cmd_hit(cv, cb)) m_auto = cb[3];
      m_sa = {m_sa[SYNC-2:0], above};
      m_sb = {m_sb[SYNC-2:0], below};
    end
  end

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // per-cycle comparison and event counters
  always @(negedge clk) begin
    cycles++;
    if (!rst) begin
      chk(field_sel == m_field, "R2/R5/R7 field_sel", field_sel, m_field);
      chk(wake_pulse == m_wake, "R4 wake_pulse", wake_pulse, m_wake);
      chk(host_reset_req == (m_rc != 0), "R6 host_reset_req", host_reset_req, m_rc != 0);
      if (wake_pulse) wake_cnt++;
      if (host_reset_req) req_cycles++;
    end
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk); cv = 1'b1; cb = b;
    @(negedge clk); cv = 1'b0; cb = 8'h00;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; above = 0; below = 0; cv = 0;
    wait_n(3); rst = 1'b0;
  endtask

  initial begin
    do_reset();
    @(negedge clk);
    // R1 reset state
    chk(field_sel == 0, "R1 field_sel", field_sel, 0);
    chk(wake_pulse == 0 && host_reset_req == 0, "R1 pulses", wake_pulse | host_reset_req, 0);

    // R3 short high run
    wake_cnt = 0;
    above = 1; wait_n(ON - 1); above = 0; wait_n(ON + 5);
    chk(field_sel == 0, "R3 glitch no switch", field_sel, 0);
    chk(wake_cnt == 0, "R3 glitch no wake", wake_cnt, 0);

    // R2/R4 qualified high run
    above = 1; wait_n(ON + SYNC + 3); above = 0;
    chk(field_sel == 1, "R2 switched to field", field_sel, 1);
    chk(wake_cnt == 1, "R4 one wake", wake_cnt, 1);

    // R5 short loss then qualified loss; R6 request width
    req_cycles = 0;
    below = 1; wait_n(OFF - 1); below = 0; wait_n(5);
    chk(field_sel == 1, "R5 short loss ignored", field_sel, 1);
    chk(req_cycles == 0, "R6 no request on short loss", req_cycles, 0);
    below = 1; wait_n(OFF + SYNC + 3); below = 0; wait_n(RLEN + 3);
    chk(field_sel == 0, "R5 back to battery", field_sel, 0);
    chk(req_cycles == RLEN, "R6 request width", req_cycles, RLEN);

    // R9 non-matching bytes
    send(8'h47); send(8'hC6); send(8'h07);
    above = 1; wait_n(ON + SYNC + 3);
    chk(field_sel == 1, "R9 ignored bytes", field_sel, 1);

    // R7 disable from field: battery, no wake, no request
    wake_cnt = 0; req_cycles = 0;
    send(8'hC7); wait_n(2);
    chk(field_sel == 0, "R7 disable forces battery", field_sel, 0);
    wait_n(3 * ON);
    chk(req_cycles == 0 && wake_cnt == 0, "R7 no pulses", req_cycles + wake_cnt, 0);
    chk(field_sel == 0, "R10 held while disabled", field_sel, 0);

    // R8 re-enable, qualification from zero
    send(8'hEF); wait_n(ON + SYNC + 3);
    chk(field_sel == 1, "R8 re-enabled", field_sel, 1);

    // R10 disable persists until power-on reset
    send(8'hF7); wait_n(4 * ON);
    chk(field_sel == 0, "R10 disabled", field_sel, 0);
    do_reset(); above = 1; wait_n(ON + SYNC + 3); above = 0;
    chk(field_sel == 1, "R10 reset re-enables", field_sel, 1);

    // random phase checked against the model
    void'($urandom(32'h5EED));
    for (int k = 0; k < 300; k++) begin
      int r = $urandom_range(0, 9);
      if (r < 4) begin above = 1; below = 0; wait_n($urandom_range(1, 2 * ON)); end
      else if (r < 7) begin above = 0; below = 1; wait_n($urandom_range(1, 2 * OFF)); end
      else if (r < 9) begin above = 0; below = 0; wait_n($urandom_range(1, 8)); end
      else send(8'hC7 | (8'($urandom_range(0, 1)) << 3) | (8'($urandom_range(0, 3)) << 4));
    end
    above = 0; below = 0; wait_n(4);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule